// File: doc/BRIEF.md
# Leveled Interrupt Controller with DMA Steering

This block collects requests from twenty peripheral sources and one non-maskable input, keeps a pending flag per source, and offers the CPU the single most urgent one. Each source carries a programmable 3-bit urgency level. The block names the winner by its vector number and its level. A current mask level gates which winners may be offered. Accepting a request raises the mask and saves the old value on an internal stack. A return pulse restores the saved value. This gives nested interrupt handling without CPU-side bookkeeping.

Four steering registers each hold a vector number. A pending, enabled source whose vector appears in one of them never reaches the CPU. Instead it raises the start line of the matching DMA channel, and it is cleared when that channel acknowledges. All configuration goes through a small register port. Each source's urgency level and pending flag can be read back through the same port.

Vector numbering: the non-maskable input is vector 0, and source i (0..19) is vector i+1. The CPU side is a valid/ready pair. `irq_valid` stays high while a request qualifies, and the request is taken on a clock edge where `irq_valid` and `irq_ready` are both high. Back-pressure is unlimited: the CPU may hold `irq_ready` low for any number of cycles. Until acceptance, the offered vector and level may change when a more urgent request arrives or when the mask moves. Each DMA channel uses the same rules with `dma_start`/`dma_ack`.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A rising edge on `src_req[i]` sets source i's pending flag at that clock edge. A register read at address i returns the level in bits [2:0] and the pending flag in bit 3.
- R2: A write to address i stores bits [2:0] as the level. Bit 3 written as 0 clears the pending flag, and bit 3 written as 1 leaves it alone. A rising edge in the same cycle as such a clear leaves the flag set.
- R3: A source whose level is 0 or 7 is never offered to the CPU and never starts a DMA channel, though its pending flag still sets.
- R4: Among enabled, unsteered pending sources the highest level wins, and equal levels go to the lowest vector.
- R5: A maskable winner is offered (`irq_valid`=1) only when its level is strictly above `cur_mask`.
- R6: On acceptance the accepted source's pending flag clears, and `cur_mask` becomes the accepted level plus 1, capped at 7. The previous mask is pushed onto the stack.
- R7: An `irq_ret` pulse pops the stack into `cur_mask`. With an empty stack the pulse leaves `cur_mask` unchanged, and it is ignored in a cycle that also accepts.
- R8: A rising edge on `nmi_req` makes a request offered with vector 0 and level 7 regardless of the mask, ahead of every other source.
- R9: If DMA register k (address 32+k) holds vector v (nonzero), a pending enabled source v-1 drives `dma_start[k]`=1 and no CPU request. On `dma_ack[k]` its flag clears and `cur_mask` does not move.
- R10: The stack holds 8 entries. A push onto a full stack is dropped and sets `stack_err`, which stays set until reset.
- R11: After reset all levels, pending flags, steering registers and the mask are 0, and `irq_valid`, `dma_start` and `stack_err` are low.
- R12: Reading address 32+k returns the steering vector of DMA channel k in bits [4:0], where 0 means unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 20 | Peripheral request lines, edge-latched |
| nmi_req | input | 1 | Non-maskable request, edge-latched |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address (0..19 sources, 32..35 steering) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_valid | output | 1 | CPU request offered |
| irq_ready | input | 1 | CPU takes the offered request |
| irq_level | output | 3 | Level of the offered request |
| irq_vector | output | 5 | Vector of the offered request |
| irq_ret | input | 1 | Return-from-interrupt pulse |
| cur_mask | output | 3 | Current mask level |
| stack_err | output | 1 | Sticky mask-stack overflow flag |
| dma_start | output | 4 | DMA channel start requests |
| dma_ack | input | 4 | DMA channel acknowledges |

## Verification
A request edge or a register write takes effect at the clock edge that samples it. The pending flag, `irq_valid`, `irq_vector`, `dma_start` and read data change combinationally from that state, so they are due one edge after the stimulus. An acceptance, return or DMA acknowledge updates the mask and the flags at the edge that samples it. The bench therefore drives inputs just after a rising edge and samples every output at the following falling edge, once exactly one register stage has been passed. A scoreboard queue holds the vector and level expected for each acceptance, and a monitor compares them at the falling edge before the accepting edge.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int LVLW = 3;
  typedef logic [LVLW-1:0] lvl_t;
  localparam lvl_t LVL_OFF = 3'd0;
  localparam lvl_t LVL_TOP = 3'd7;

  function automatic lvl_t mask_after(input lvl_t lvl);
    return (lvl == LVL_TOP) ? LVL_TOP : lvl + 3'd1;
  endfunction
endpackage

// File: rtl/lic_req_bank.sv
module lic_req_bank #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_req,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] src_q;

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        src_q[i] <= 1'b0;
        pend[i]  <= 1'b0;
      end else begin
        src_q[i] <= src_req[i];
        // a new edge wins over any clear in the same cycle
        pend[i]  <= (src_req[i] & ~src_q[i]) | (pend[i] & ~clr[i]);
      end
    end
  end
endmodule

// File: rtl/lic_arbiter.sv
module lic_arbiter import lic_pkg::*; #(
  parameter int N  = 20,
  parameter int VW = 5
) (
  input  logic [N-1:0]      elig,
  input  logic [N*LVLW-1:0] lvl_flat,
  output logic              found,
  output logic [VW-1:0]     win_idx,
  output lvl_t              win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = LVL_OFF;
    // strict compare keeps the lowest index on equal levels
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (lvl_flat[i*LVLW +: LVLW] > win_lvl)) begin
        found   = 1'b1;
        win_idx = VW'(i);
        win_lvl = lvl_flat[i*LVLW +: LVLW];
      end
    end
  end
endmodule

// File: rtl/lic_mask_stack.sv
module lic_mask_stack import lic_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  lvl_t push_val,
  input  logic pop,
  output lvl_t top,
  output logic empty,
  output logic err
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  lvl_t          mem [DEPTH];
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign top   = empty ? LVL_OFF : mem[IW'(cnt - CW'(1))];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= LVL_OFF;
    end else if (push) begin
      if (cnt == CW'(DEPTH)) begin
        err <= 1'b1;
      end else begin
        mem[IW'(cnt)] <= push_val;
        cnt <= cnt + CW'(1);
      end
    end else if (pop && !empty) begin
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl import lic_pkg::*; #(
  parameter int NSRC      = 20,
  parameter int NDMA      = 4,
  parameter int STK_DEPTH = 8,
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int DMA_BASE  = 32,
  parameter int VW        = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            nmi_req,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_valid,
  input  logic            irq_ready,
  output logic [2:0]      irq_level,
  output logic [VW-1:0]   irq_vector,
  input  logic            irq_ret,
  output logic [2:0]      cur_mask,
  output logic            stack_err,
  output logic [NDMA-1:0] dma_start,
  input  logic [NDMA-1:0] dma_ack
);
  lvl_t            lvl_q  [NSRC];
  logic [VW-1:0]   dvec_q [NDMA];
  logic [NSRC-1:0] pend, en, steer, elig, clr, dma_clr;
  logic [NSRC*LVLW-1:0] lvl_flat;
  logic            nmi_q, nmi_pend;
  logic            found, take, take_cpu, take_nmi, pop;
  logic [VW-1:0]   win_idx;
  lvl_t            win_lvl, mask_q, stk_top;
  logic            stk_empty;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata[DW-1:VW];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= LVL_OFF;
      for (int k = 0; k < NDMA; k++) dvec_q[k] <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NSRC; i++)
        if (reg_addr == AW'(i)) lvl_q[i] <= reg_wdata[LVLW-1:0];
      for (int k = 0; k < NDMA; k++)
        if (reg_addr == AW'(DMA_BASE + k)) dvec_q[k] <= reg_wdata[VW-1:0];
    end
  end

  // enable, steering and DMA start decode
  always_comb begin
    dma_clr   = '0;
    dma_start = '0;
    for (int i = 0; i < NSRC; i++) begin
      en[i]    = (lvl_q[i] != LVL_OFF) && (lvl_q[i] != LVL_TOP);
      steer[i] = 1'b0;
      for (int k = 0; k < NDMA; k++)
        if (dvec_q[k] == VW'(i + 1)) steer[i] = 1'b1;
    end
    for (int k = 0; k < NDMA; k++)
      for (int i = 0; i < NSRC; i++)
        if ((dvec_q[k] == VW'(i + 1)) && pend[i] && en[i]) begin
          dma_start[k] = 1'b1;
          if (dma_ack[k]) dma_clr[i] = 1'b1;
        end
  end

  assign elig = pend & en & ~steer;

  for (genvar i = 0; i < NSRC; i++) begin : g_pack
    assign lvl_flat[i*LVLW +: LVLW] = lvl_q[i];
    assign clr[i] = (reg_wr && (reg_addr == AW'(i)) && !reg_wdata[3])
                  || (take_cpu && (win_idx == VW'(i)))
                  || dma_clr[i];
  end

  lic_req_bank #(.N(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .clr(clr), .pend(pend)
  );

  lic_arbiter #(.N(NSRC), .VW(VW)) u_arb (
    .elig(elig), .lvl_flat(lvl_flat), .found(found),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  // non-maskable source
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_req;
      nmi_pend <= (nmi_req & ~nmi_q) | (nmi_pend & ~take_nmi);
    end
  end

  // CPU offer
  always_comb begin
    if (nmi_pend) begin
      irq_valid  = 1'b1;
      irq_level  = LVL_TOP;
      irq_vector = '0;
    end else begin
      irq_valid  = found && (win_lvl > mask_q);
      irq_level  = win_lvl;
      irq_vector = win_idx + VW'(1);
    end
  end

  assign take     = irq_valid & irq_ready;
  assign take_nmi = take & nmi_pend;
  assign take_cpu = take & ~nmi_pend;
  assign pop      = irq_ret & ~take & ~stk_empty;

  lic_mask_stack #(.DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(take), .push_val(mask_q),
    .pop(pop), .top(stk_top), .empty(stk_empty), .err(stack_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    mask_q <= LVL_OFF;
    else if (take) mask_q <= mask_after(irq_level);
    else if (pop)  mask_q <= stk_top;
  end

  assign cur_mask = mask_q;

  // register read-back
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NSRC; i++)
      if (reg_addr == AW'(i)) reg_rdata = {{(DW-4){1'b0}}, pend[i], lvl_q[i]};
    for (int k = 0; k < NDMA; k++)
      if (reg_addr == AW'(DMA_BASE + k)) reg_rdata = {{(DW-VW){1'b0}}, dvec_q[k]};
  end
endmodule

// File: rtl/lic_checks.sv
module lic_checks #(
  parameter int NDMA = 4,
  parameter int VW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_valid,
  input logic            irq_ready,
  input logic [2:0]      irq_level,
  input logic [VW-1:0]   irq_vector,
  input logic            irq_ret,
  input logic [2:0]      cur_mask,
  input logic            stack_err,
  input logic [NDMA-1:0] dma_start,
  input logic [NDMA-1:0] dma_ack
);
  p_offer_above_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector != '0) |-> (irq_level > cur_mask));

  p_offer_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_level != 3'd0));

  p_nmi_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_vector == '0) |-> (irq_level == 3'd7));

  p_mask_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=>
      (cur_mask == (($past(irq_level) == 3'd7) ? 3'd7 : $past(irq_level) + 3'd1)));

  p_dma_mask_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(dma_start & dma_ack)) && !(irq_valid && irq_ready) && !irq_ret) |=> $stable(cur_mask));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |=> stack_err);
endmodule

bind lvl_irq_ctrl lic_checks #(.NDMA(NDMA), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready),
  .irq_level(irq_level), .irq_vector(irq_vector), .irq_ret(irq_ret),
  .cur_mask(cur_mask), .stack_err(stack_err), .dma_start(dma_start),
  .dma_ack(dma_ack)
);

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/100ps
module tb_lvl_irq_ctrl;
  localparam int N = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic        nmi_req = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [2:0]  irq_level;
  logic [4:0]  irq_vector;
  logic        irq_ret = 1'b0;
  logic [2:0]  cur_mask;
  logic        stack_err;
  logic [3:0]  dma_start;
  logic [3:0]  dma_ack = '0;

  int errs = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] expq [$];

  always #2.5 clk = ~clk;

  lvl_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .nmi_req(nmi_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_level(irq_level), .irq_vector(irq_vector), .irq_ret(irq_ret),
    .cur_mask(cur_mask), .stack_err(stack_err), .dma_start(dma_start),
    .dma_ack(dma_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    reg_addr = a; @(negedge clk); chk(req, reg_rdata, exp); tick();
  endtask

  task automatic pulse(input logic [N-1:0] m);
    src_req = src_req | m; tick(); src_req = src_req & ~m; tick();
  endtask

  task automatic nmi_pulse();
    nmi_req = 1'b1; tick(); nmi_req = 1'b0; tick();
  endtask

  // driver: push the expected vector/level, then let the CPU take it
  task automatic take(input logic [4:0] vec, input logic [2:0] lvl);
    expq.push_back({vec, lvl}); irq_ready = 1'b1; tick(); irq_ready = 1'b0;
  endtask

  task automatic ret();
    irq_ret = 1'b1; tick(); irq_ret = 1'b0;
  endtask

  // monitor: compares each acceptance against the scoreboard
  always @(negedge clk) begin
    if (irq_ready) begin
      checks++;
      if (!irq_valid || expq.size() == 0) begin
        errs++;
        $display("FAIL R4/R6 accept: valid=%0b queued=%0d expected a request", irq_valid, expq.size());
        if (expq.size() != 0) void'(expq.pop_front());
      end else begin
        logic [7:0] e;
        e = expq.pop_front();
        if ({irq_vector, irq_level} !== e) begin
          errs++;
          $display("FAIL R4/R8 accept: actual vec=%0d lvl=%0d expected vec=%0d lvl=%0d",
                   irq_vector, irq_level, e[7:3], e[2:0]);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(); tick(); rst_n = 1'b1; tick();
    // R11 reset state
    @(negedge clk);
    chk("R11 mask", cur_mask, 0);
    chk("R11 valid", irq_valid, 0);
    chk("R11 dma", dma_start, 0);
    chk("R11 err", stack_err, 0);
    tick();
    rd_chk("R11 ch0", 6'd0, 8'h00);

    wr(6'd3, 8'h02); wr(6'd5, 8'h04); wr(6'd7, 8'h04); wr(6'd10, 8'h00);
    pulse((N'(1) << 3) | (N'(1) << 5) | (N'(1) << 7) | (N'(1) << 10));
    rd_chk("R1 ch10 pending", 6'd10, 8'h08);
    rd_chk("R1 ch3 pending", 6'd3, 8'h0A);

    take(5'd6, 3'd4);                       // R4 level 4 beats level 2
    @(negedge clk);
    chk("R6 mask raise", cur_mask, 5);
    chk("R5 blocked by mask", irq_valid, 0);
    tick();
    rd_chk("R6 flag cleared", 6'd5, 8'h04);
    ret();
    @(negedge clk); chk("R7 restore", cur_mask, 0); tick();
    take(5'd8, 3'd4);                       // R4 tie went to lower vector first
    ret();
    take(5'd4, 3'd2);
    ret();
    @(negedge clk); chk("R3 level0 not offered", irq_valid, 0); tick();
    wr(6'd10, 8'h0F);                       // level 7, clear bit 1: keep flag
    @(negedge clk); chk("R3 level7 not offered", irq_valid, 0); tick();
    rd_chk("R2 bit3=1 keeps flag", 6'd10, 8'h0F);
    wr(6'd10, 8'h07);
    rd_chk("R2 software clear", 6'd10, 8'h07);

    // R2 edge in the same cycle as a clear
    src_req[3] = 1'b1;
    wr(6'd3, 8'h02);
    src_req[3] = 1'b0; tick();
    rd_chk("R2 edge beats clear", 6'd3, 8'h0A);
    take(5'd4, 3'd2);
    ret();

    // R8 non-maskable request above mask 7
    wr(6'd1, 8'h06);
    pulse(N'(1) << 1);
    take(5'd2, 3'd6);
    @(negedge clk); chk("R6 mask cap", cur_mask, 7); tick();
    nmi_pulse();
    @(negedge clk); chk("R8 nmi offered", {irq_valid, irq_vector, irq_level}, {1'b1, 5'd0, 3'd7}); tick();
    take(5'd0, 3'd7);
    ret(); ret();
    @(negedge clk); chk("R7 unwound", cur_mask, 0); tick();

    // R9 / R12 DMA steering
    wr(6'd33, 8'd12);
    rd_chk("R12 steering readback", 6'd33, 8'd12);
    wr(6'd11, 8'h03);
    pulse(N'(1) << 11);
    @(negedge clk);
    chk("R9 dma start", dma_start, 4'b0010);
    chk("R9 no cpu request", irq_valid, 0);
    tick();
    dma_ack = 4'b0010; tick(); dma_ack = '0;
    @(negedge clk);
    chk("R9 start dropped", dma_start, 0);
    chk("R9 mask kept", cur_mask, 0);
    tick();
    rd_chk("R9 flag cleared", 6'd11, 8'h03);

    // R10 stack overflow via repeated non-maskable requests
    for (int n = 0; n < 9; n++) begin
      nmi_pulse();
      take(5'd0, 3'd7);
      if (n == 7) begin
        @(negedge clk); chk("R10 full no err", stack_err, 0); tick();
      end
    end
    @(negedge clk); chk("R10 overflow err", stack_err, 1); tick();
    for (int n = 0; n < 7; n++) ret();
    @(negedge clk); chk("R7 inner restore", cur_mask, 7); tick();
    ret();
    @(negedge clk); chk("R10 dropped push", cur_mask, 0); tick();
    ret();
    @(negedge clk);
    chk("R7 empty stack", cur_mask, 0);
    chk("R10 err sticky", stack_err, 1);
    chk("R6 scoreboard drained", expq.size(), 0);
    tick();
    finish_run();
  end
endmodule